// File: doc/BRIEF.md
# Converter Master Serial Output Controller

This block is the digital output stage of an 18-bit data converter working as serial master. A conversion-start pulse begins a conversion phase of fixed length, which stands in for the analog core. While the phase runs, `busy` is high. At the end of the phase the block latches the code on `sample_code` as the new result. It then shifts a result out most significant bit first on `ser_data`, together with a serial clock `ser_clk` and a frame-valid strobe `frame_sync`, all generated from the system clock.

There are two read timings. In read-after mode the fresh result is shifted out once the conversion phase ends, and `busy` stays high until the last bit has gone out. In read-during mode the result of the previous conversion is shifted out while the new conversion runs, and `busy` covers only the conversion phase. When `ext_clk_mode` is high the block is not the clock master: it still converts, but its serial pins stay idle.

The polarity of the serial clock and of the strobe can each be inverted. A divider select halves the serial clock rate for slow hosts.

The control FSM has four states:
- `CS_IDLE`: waits for a start pulse, then goes to `CS_CONV`.
- `CS_CONV`: counts the conversion phase. At its end it goes to `CS_IDLE` (read-during mode, or slave mode) or to `CS_RD_WAIT` (read-after master).
- `CS_RD_WAIT`: launches the frame once the shifter is free, then goes to `CS_RD_SHIFT`.
- `CS_RD_SHIFT`: returns to `CS_IDLE` on the frame-done pulse.

The shifter FSM has two states:
- `FS_IDLE`: goes to `FS_SHIFT` on a launch.
- `FS_SHIFT`: returns to `FS_IDLE` after the last phase of the last bit.

Top module: `conv_serial_master`

## Requirements
- R1: During and right after a synchronous active-high reset, `busy`=0, `ser_data`=0, `ser_clk` equals `sclk_invert` and `frame_sync` equals `sync_invert`.
- R2: A `conv_start` pulse sampled while `busy` is low raises `busy` on the next cycle. The conversion lasts CONV_CYCLES (32) clocks. In read-during mode and in slave mode, `busy` is high for exactly 32 cycles.
- R3: A `conv_start` pulse sampled while `busy` is high is ignored: the `busy` profile and the frame are unchanged.
- R4: Read-after mode (`read_during`=0 when the start is accepted) works as follows. The frame begins one cycle after the conversion ends and carries the `sample_code` value held at the end of that conversion. `busy` stays high for 33+18·P cycles and falls in the same cycle that `frame_sync` deasserts.
- R5: Read-during mode (`read_during`=1 when the start is accepted) works as follows. The frame begins RDC_LEAD (2) cycles after `busy` rises and carries the result of the previous conversion. After reset that result is 0.
- R6: A frame carries 18 bits, D17 first and D0 last. Each bit lasts P clocks. The non-inverted clock is low for the first P/2 clocks of a bit and high for the second P/2. `ser_data` changes only when the non-inverted clock falls.
- R7: P=2 when `sclk_slow`=0 and P=4 when `sclk_slow`=1. The select is sampled when the frame begins; later changes have no effect on that frame.
- R8: `sclk_invert`=1 inverts `ser_clk` at all times, so its idle level equals `sclk_invert`.
- R9: `frame_sync` is asserted during the frame and deasserted otherwise. The asserted level is 1 when `sync_invert`=0 and 0 when `sync_invert`=1.
- R10: If `ext_clk_mode` is high when a start is accepted, no frame is produced and the serial pins stay idle. The conversion still runs with a 32-cycle `busy` and updates the stored result.
- R11: In read-during mode, a frame whose launch falls while an earlier frame is still shifting is dropped. The earlier frame finishes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion-start pulse |
| ext_clk_mode | input | 1 | High: not serial master, serial pins idle |
| read_during | input | 1 | High: shift the previous result during conversion |
| sclk_invert | input | 1 | Invert the serial clock |
| sync_invert | input | 1 | Invert the frame strobe |
| sclk_slow | input | 1 | High: serial clock at clk/4, otherwise clk/2 |
| sample_code | input | 18 | Code the analog stand-in delivers at conversion end |
| busy | output | 1 | Conversion (and, in read-after mode, readout) in progress |
| frame_sync | output | 1 | Frame-valid strobe |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with its default parameters: 18-bit words, a 32-clock conversion, a 2-clock read-during lead, and half-periods of 1 and 2 clocks. It sweeps every combination of the five mode pins (read timing, divider, both polarities, master or slave) and checks `busy`, `ser_clk`, `frame_sync` and `ser_data` cycle by cycle against a model computed arithmetically. Each run also carries an ignored start pulse during `busy` and a divider flip just after frame launch. The 32-cycle conversion is short against a slow 72-cycle frame, which brings the dropped-frame overlap in read-during mode within reach.

// File: rtl/csm_pkg.sv
package csm_pkg;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_CONV,
        CS_RD_WAIT,
        CS_RD_SHIFT
    } ctl_state_t;

    typedef enum logic {
        FS_IDLE,
        FS_SHIFT
    } frm_state_t;

endpackage

// File: rtl/csm_conv_ctrl.sv
module csm_conv_ctrl
    import csm_pkg::*;
#(
    parameter int CONV_CYCLES = 32,
    parameter int RDC_LEAD    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_start,
    input  logic ext_clk_mode,
    input  logic read_during,
    input  logic frame_active,
    input  logic frame_done,
    output logic busy,
    output logic frame_go,
    output logic capture,
    output logic lat_rdc
);

    localparam int CNT_W = $clog2(CONV_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LEAD = CNT_W'(RDC_LEAD - 1);

    ctl_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             lat_ext;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= CS_IDLE;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE:     if (conv_start) state_nx = CS_CONV;
            CS_CONV:     if (cnt == CNT_LAST)
                             state_nx = (lat_ext || lat_rdc) ? CS_IDLE : CS_RD_WAIT;
            CS_RD_WAIT:  if (!frame_active) state_nx = CS_RD_SHIFT;
            CS_RD_SHIFT: if (frame_done) state_nx = CS_IDLE;
            default:     state_nx = CS_IDLE;
        endcase
    end

    // counter and mode latches
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            lat_rdc <= 1'b0;
            lat_ext <= 1'b0;
        end else if (state == CS_IDLE && conv_start) begin
            cnt     <= '0;
            lat_rdc <= read_during;
            lat_ext <= ext_clk_mode;
        end else if (state == CS_CONV) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        frame_go = 1'b0;
        capture  = 1'b0;
        unique case (state)
            CS_IDLE: ;
            CS_CONV: begin
                busy     = 1'b1;
                capture  = (cnt == CNT_LAST);
                frame_go = lat_rdc && !lat_ext && (cnt == CNT_LEAD) && !frame_active;
            end
            CS_RD_WAIT: begin
                busy     = 1'b1;
                frame_go = !frame_active;
            end
            CS_RD_SHIFT: busy = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/csm_frame_shifter.sv
module csm_frame_shifter
    import csm_pkg::*;
#(
    parameter int DATA_W    = 18,
    parameter int FAST_HALF = 1,
    parameter int SLOW_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              slow_sel,
    input  logic [DATA_W-1:0] word,
    output logic              active,
    output logic              done,
    output logic              sclk_raw,
    output logic              sdata_raw
);

    localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int PH_W     = $clog2(2 * MAX_HALF) + 1;
    localparam int BC_W     = $clog2(DATA_W);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(DATA_W - 1);
    localparam logic [PH_W-1:0] FAST_H   = PH_W'(FAST_HALF);
    localparam logic [PH_W-1:0] SLOW_H   = PH_W'(SLOW_HALF);
    localparam logic [PH_W-1:0] FAST_E   = PH_W'(2 * FAST_HALF - 1);
    localparam logic [PH_W-1:0] SLOW_E   = PH_W'(2 * SLOW_HALF - 1);

    frm_state_t        st, st_nx;
    logic [DATA_W-1:0] shreg;
    logic [BC_W-1:0]   bit_cnt;
    logic [PH_W-1:0]   phase;
    logic [PH_W-1:0]   half_q;
    logic [PH_W-1:0]   end_q;
    logic              phase_end;

    assign phase_end = (phase == end_q);

    always_ff @(posedge clk) begin
        if (rst) st <= FS_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            FS_IDLE:  if (go) st_nx = FS_SHIFT;
            FS_SHIFT: if (phase_end && bit_cnt == BIT_LAST) st_nx = FS_IDLE;
            default:  st_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            phase   <= '0;
            half_q  <= FAST_H;
            end_q   <= FAST_E;
        end else if (st == FS_IDLE) begin
            if (go) begin
                shreg   <= word;
                bit_cnt <= '0;
                phase   <= '0;
                half_q  <= slow_sel ? SLOW_H : FAST_H;
                end_q   <= slow_sel ? SLOW_E : FAST_E;
            end
        end else if (phase_end) begin
            phase   <= '0;
            shreg   <= shreg << 1;
            bit_cnt <= bit_cnt + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        active    = 1'b0;
        done      = 1'b0;
        sclk_raw  = 1'b0;
        sdata_raw = 1'b0;
        unique case (st)
            FS_IDLE: ;
            FS_SHIFT: begin
                active    = 1'b1;
                done      = phase_end && (bit_cnt == BIT_LAST);
                sclk_raw  = (phase >= half_q);
                sdata_raw = shreg[DATA_W-1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/csm_pin_stage.sv
module csm_pin_stage (
    input  logic sclk_raw,
    input  logic sync_raw,
    input  logic sdata_raw,
    input  logic sclk_invert,
    input  logic sync_invert,
    output logic ser_clk,
    output logic frame_sync,
    output logic ser_data
);

    always_comb begin
        ser_clk    = sclk_raw ^ sclk_invert;
        frame_sync = sync_raw ^ sync_invert;
        ser_data   = sdata_raw & sync_raw;
    end

endmodule

// File: rtl/conv_serial_master.sv
module conv_serial_master #(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 32,
    parameter int RDC_LEAD    = 2,
    parameter int FAST_HALF   = 1,
    parameter int SLOW_HALF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              ext_clk_mode,
    input  logic              read_during,
    input  logic              sclk_invert,
    input  logic              sync_invert,
    input  logic              sclk_slow,
    input  logic [DATA_W-1:0] sample_code,
    output logic              busy,
    output logic              frame_sync,
    output logic              ser_clk,
    output logic              ser_data
);

    logic              frame_active;
    logic              frame_done;
    logic              frame_go;
    logic              capture;
    logic              lat_rdc;
    logic              sclk_raw;
    logic              sdata_raw;
    logic [DATA_W-1:0] result_q;

    csm_conv_ctrl #(
        .CONV_CYCLES (CONV_CYCLES),
        .RDC_LEAD    (RDC_LEAD)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .conv_start   (conv_start),
        .ext_clk_mode (ext_clk_mode),
        .read_during  (read_during),
        .frame_active (frame_active),
        .frame_done   (frame_done),
        .busy         (busy),
        .frame_go     (frame_go),
        .capture      (capture),
        .lat_rdc      (lat_rdc)
    );

    // result of the most recent conversion
    always_ff @(posedge clk) begin
        if (rst)          result_q <= '0;
        else if (capture) result_q <= sample_code;
    end

    csm_frame_shifter #(
        .DATA_W    (DATA_W),
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .go        (frame_go),
        .slow_sel  (sclk_slow),
        .word      (result_q),
        .active    (frame_active),
        .done      (frame_done),
        .sclk_raw  (sclk_raw),
        .sdata_raw (sdata_raw)
    );

    csm_pin_stage u_pins (
        .sclk_raw    (sclk_raw),
        .sync_raw    (frame_active),
        .sdata_raw   (sdata_raw),
        .sclk_invert (sclk_invert),
        .sync_invert (sync_invert),
        .ser_clk     (ser_clk),
        .frame_sync  (frame_sync),
        .ser_data    (ser_data)
    );

endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int DATA_W = 18
) (
    input logic clk,
    input logic rst,
    input logic conv_start,
    input logic busy,
    input logic frame_sync,
    input logic ser_clk,
    input logic ser_data,
    input logic sclk_invert,
    input logic sync_invert,
    input logic frame_active,
    input logic sclk_raw,
    input logic sdata_raw,
    input logic lat_rdc
);

    localparam int RC_W = $clog2(DATA_W + 1) + 1;

    logic [RC_W-1:0] rise_cnt;
    logic            sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_raw;
            if (!frame_active)            rise_cnt <= '0;
            else if (sclk_raw && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R8 R9 R10: outside a frame the pins rest at their idle levels
    a_r8_idle_levels: assert property (@(posedge clk) disable iff (rst)
        !frame_active |-> (ser_clk == sclk_invert && frame_sync == sync_invert && ser_data == 1'b0));

    // R3: busy only ever rises in answer to a start pulse
    a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(conv_start));

    // R4: a read-after frame lies entirely inside busy
    a_r4_busy_covers_frame: assert property (@(posedge clk) disable iff (rst)
        (frame_active && !lat_rdc) |-> busy);

    // R6: data does not move when the clock rises
    a_r6_data_stable_on_rise: assert property (@(posedge clk) disable iff (rst)
        (frame_active && $rose(sclk_raw)) |-> $stable(sdata_raw));

    // R6: every frame carries exactly DATA_W clock pulses
    a_r6_pulse_count: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_active) |-> (rise_cnt == RC_W'(DATA_W)));

endmodule

bind conv_serial_master csm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_start   (conv_start),
    .busy         (busy),
    .frame_sync   (frame_sync),
    .ser_clk      (ser_clk),
    .ser_data     (ser_data),
    .sclk_invert  (sclk_invert),
    .sync_invert  (sync_invert),
    .frame_active (frame_active),
    .sclk_raw     (sclk_raw),
    .sdata_raw    (sdata_raw),
    .lat_rdc      (lat_rdc)
);

// File: tb/conv_serial_master_tb.sv
module conv_serial_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 18;
    localparam int CONV       = 32;
    localparam int LEAD       = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic         conv_start;
    logic         ext_clk_mode;
    logic         read_during;
    logic         sclk_invert;
    logic         sync_invert;
    logic         sclk_slow;
    logic [W-1:0] sample_code;
    logic         busy;
    logic         frame_sync;
    logic         ser_clk;
    logic         ser_data;

    int           checks   = 0;
    int           failures = 0;
    bit           finished = 1'b0;
    logic [W-1:0] prev_word = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    conv_serial_master dut_i (
        .clk          (clk),
        .rst          (rst),
        .conv_start   (conv_start),
        .ext_clk_mode (ext_clk_mode),
        .read_during  (read_during),
        .sclk_invert  (sclk_invert),
        .sync_invert  (sync_invert),
        .sclk_slow    (sclk_slow),
        .sample_code  (sample_code),
        .busy         (busy),
        .frame_sync   (frame_sync),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp,
                         input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one conversion, checked cycle by cycle at falling edges
    task automatic run_conv(input logic [W-1:0] word, input bit rdc, input bit slow,
                            input bit sinv, input bit yinv, input bit ext,
                            input int second_at, input string tag);
        int p, flen, fs, busy_end, len;
        int eb, ec, ey, ed;
        int ab, xb, ac, xc, ay, xy, ad, xd;
        logic [W-1:0] w;
        p    = slow ? 4 : 2;                     // R7
        flen = W * p;
        fs   = ext ? -1 : (rdc ? LEAD : CONV + 1);
        busy_end = (ext || rdc) ? CONV : CONV + 1 + flen;
        w    = rdc ? prev_word : word;
        len  = ((busy_end > fs + flen) ? busy_end : fs + flen) + 3;
        if (second_at > 0 && second_at + 36 > len) len = second_at + 36;
        eb = 0; ec = 0; ey = 0; ed = 0;
        ab = 0; xb = 0; ac = 0; xc = 0; ay = 0; xy = 0; ad = 0; xd = 0;
        @(negedge clk);
        sample_code  = word;
        read_during  = rdc;
        sclk_slow    = slow;
        sclk_invert  = sinv;
        sync_invert  = yinv;
        ext_clk_mode = ext;
        conv_start   = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        for (int off = 0; off < len; off++) begin
            bit in_f, b_e, c_e, y_e, d_e;
            int rel, bi, h;
            in_f = (fs >= 0) && (off >= fs) && (off < fs + flen);
            b_e  = (off < busy_end) ||
                   (second_at > 0 && off > second_at && off <= second_at + CONV);
            rel  = in_f ? off - fs : 0;
            bi   = rel / p;
            h    = rel % p;
            c_e  = (in_f && (h >= p / 2)) ^ sinv;
            y_e  = in_f ^ yinv;
            d_e  = in_f ? w[W-1-bi] : 1'b0;
            if (busy !== b_e && eb == 0) begin ab = busy; xb = b_e; end
            if (busy !== b_e) eb++;
            if (ser_clk !== c_e && ec == 0) begin ac = ser_clk; xc = c_e; end
            if (ser_clk !== c_e) ec++;
            if (frame_sync !== y_e && ey == 0) begin ay = frame_sync; xy = y_e; end
            if (frame_sync !== y_e) ey++;
            if (ser_data !== d_e && ed == 0) begin ad = ser_data; xd = d_e; end
            if (ser_data !== d_e) ed++;
            // R3: extra start while busy is high
            if (off == 5) conv_start = 1'b1;
            if (off == 6) conv_start = 1'b0;
            // R11: second start once busy has dropped
            if (second_at > 0 && off == second_at)     conv_start = 1'b1;
            if (second_at > 0 && off == second_at + 1) conv_start = 1'b0;
            // R7: divider select changes after the frame has begun
            if (fs >= 0 && off == fs + 1) sclk_slow = ~slow;
            @(negedge clk);
        end
        prev_word = word;
        check(ext ? "R10 R3" : (rdc ? "R2 R3" : "R4 R3"), eb == 0, ab, xb,
              $sformatf("busy profile %s", tag));
        check("R6 R7 R8", ec == 0, ac, xc, $sformatf("ser_clk %s", tag));
        check("R9", ey == 0, ay, xy, $sformatf("frame_sync %s", tag));
        check(rdc ? "R5 R6" : "R4 R6", ed == 0, ad, xd, $sformatf("ser_data %s", tag));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R2 run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        rst          = 1'b1;
        conv_start   = 1'b0;
        ext_clk_mode = 1'b0;
        read_during  = 1'b0;
        sclk_invert  = 1'b0;
        sync_invert  = 1'b0;
        sclk_slow    = 1'b0;
        sample_code  = '0;
        repeat (3) @(negedge clk);
        // R1: reset levels
        check("R1", busy == 1'b0, busy, 0, "busy in reset");
        check("R1", ser_clk == 1'b0, ser_clk, 0, "ser_clk in reset");
        check("R1", frame_sync == 1'b0, frame_sync, 0, "frame_sync in reset");
        check("R1", ser_data == 1'b0, ser_data, 0, "ser_data in reset");
        sclk_invert = 1'b1;
        sync_invert = 1'b1;
        @(negedge clk);
        check("R1 R8", ser_clk == 1'b1, ser_clk, 1, "inverted clock idle");
        check("R1 R9", frame_sync == 1'b1, frame_sync, 1, "inverted strobe idle");
        rst = 1'b0;
        @(negedge clk);
        check("R1", busy == 1'b0, busy, 0, "busy after reset");

        for (int i = 0; i < 32; i++) begin
            logic [W-1:0] wd;
            logic [4:0]   ix;
            ix = 5'(i);
            case (i)
                0:       wd = 18'h2AAAA;
                1:       wd = 18'h3FFFF;
                2:       wd = 18'h00001;
                3:       wd = 18'h20000;
                default: wd = W'((i * 18'h0A5C3) ^ 18'h15A3C);
            endcase
            run_conv(wd, ~ix[0], ix[1], ix[2], ix[3], ix[4], 0,
                     $sformatf("sweep %0d", i));
        end

        // R11: overlapping read-during frame is dropped
        run_conv(18'h1B4E7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, CONV, "R11 overlap");
        // R5: the dropped frame's data stays the stored result
        run_conv(18'h0F0F0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R11 follow-up");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule